// File: doc/BRIEF.md
# Address Decoder with Access Trap

This block sits between a processor's bus and its memories. Every request carries a byte address. The block sorts each address into one of three regions: the ROM, the RAM, or a small window of control registers. ROM and RAM are matched against sizes that software sets at run time. An address that falls in no region raises a one-cycle memory-exception trap, and the offending address is latched so that a fault handler can read it.

The register window is 256 bytes of word storage. Two of its words have a function. The word at offset 0x00 is the control word, which exposes the access-protection, power-down and soft-reset enables. The word at offset 0x10 is the memory configuration word, which holds one size field for the ROM and one for the RAM. Every other word in the window is plain storage: a write to it is kept and can be read back, and it never traps. The ROM and RAM selects are combinational, so the memory controller sees them in the same cycle as the request. Read data from the window, the trap pulse and the response strobe come one clock later.

Top module: `addr_trap_decoder`

## Requirements
- R1: After reset the decoder maps 4 KB of ROM (0x0 to 0xFFF) and 256 KB of RAM (0x02000000 to 0x0203FFFF). All window words reset to zero, so the control outputs are low and both size fields are 0.
- R2: `sel_rom` is high in the request cycle when `req_valid` is high and the address is below 4096 shifted left by the ROM field, with that limit capped at 0x80000.
- R3: `sel_ram` is high in the request cycle when the address is at or above 0x02000000 and the offset from 0x02000000 is below 262144 shifted left by the RAM field, with that limit capped at 0x400000.
- R4: `sel_regs` is high for any address from 0x01F80000 to 0x01F800FF. Such an access never traps. A write stores the word at index addr[7:2], and a later read of that index returns it on `rsp_rdata` one cycle after the request.
- R5: A valid request outside ROM, RAM and the window keeps all selects low. One cycle later `trap_pulse` is high for exactly one cycle, `trap_addr` takes the request address, and `rsp_valid` stays low.
- R6: The memory configuration word sits at window offset 0x10. Bits [2:0] are the ROM size field and bits [10:8] are the RAM size field. The other bits are stored and read back but do not change decoding. A new value applies from the next request on.
- R7: The control word sits at window offset 0x00. Bit 0 drives `pdown_en`, bit 1 drives `sreset_en` and bit 3 drives `prot_en`. Only these three bits are stored; every other bit reads as zero.
- R8: `trap_addr` holds its value until the next trap.
- R9: `rsp_valid` pulses one cycle after each request that does not trap. `rsp_rdata` is zero on that cycle except for a read inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| sel_rom | output | 1 | Request hits configured ROM (combinational) |
| sel_ram | output | 1 | Request hits configured RAM (combinational) |
| sel_regs | output | 1 | Request hits the register window (combinational) |
| rsp_valid | output | 1 | Non-trapping request completed last cycle |
| rsp_rdata | output | 32 | Window read data, otherwise zero |
| trap_pulse | output | 1 | One-cycle memory-exception trap |
| trap_addr | output | 32 | Address of the most recent trapping request |
| prot_en | output | 1 | Access-protection enable (control bit 3) |
| pdown_en | output | 1 | Power-down enable (control bit 0) |
| sreset_en | output | 1 | Soft-reset enable (control bit 1) |

## Verification
The bench aims at the last word inside each region and the first word past it. These boundaries move whenever the configuration word is rewritten, so it probes them at the reset sizes, after growth, and at field values larger than the cap. An off-by-one limit would either trap on the last valid word or let the first invalid one through. A missing cap would let RAM or ROM decode beyond its maximum. The words just below and just above the register window check that the window test neither traps inside it nor accepts addresses beside it. Writes of all ones to the control word and to the configuration word show whether the control word keeps bits it should drop and whether the configuration word loses its spare bits. Idle cycles after each trap show whether the trap pulse stretches past one cycle or whether the latched address drifts.

// File: rtl/addr_trap_pkg.sv
package addr_trap_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_ROM  = 2'd1,
      RGN_RAM  = 2'd2,
      RGN_WIN  = 2'd3
   } region_e;

   // limit = base_min << field, saturated at max_b
   function automatic longint unsigned scaled_limit(
      input longint unsigned min_b,
      input longint unsigned max_b,
      input int unsigned     field
   );
      longint unsigned s;
      s = min_b << field;
      return (s > max_b) ? max_b : s;
   endfunction

   function automatic bit is_pow2(input longint unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/at_region_decode.sv
module at_region_decode
   import addr_trap_pkg::*;
#(
   parameter int              ADDR_W   = 32,
   parameter int              SZ_W     = 3,
   parameter longint unsigned ROM_BASE = 64'h0,
   parameter longint unsigned ROM_MIN  = 64'h1000,
   parameter longint unsigned ROM_MAX  = 64'h8_0000,
   parameter longint unsigned RAM_BASE = 64'h0200_0000,
   parameter longint unsigned RAM_MIN  = 64'h4_0000,
   parameter longint unsigned RAM_MAX  = 64'h40_0000,
   parameter longint unsigned WIN_BASE = 64'h01F8_0000,
   parameter longint unsigned WIN_SIZE = 64'h100
) (
   input  logic              valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SZ_W-1:0]   rom_field,
   input  logic [SZ_W-1:0]   ram_field,
   output region_e           region
);
   localparam int PAD_W = 64 - ADDR_W;

   longint unsigned addr_l;
   longint unsigned rom_lim;
   longint unsigned ram_lim;
   logic            hit_rom;
   logic            hit_ram;
   logic            hit_win;

   always_comb begin
      addr_l  = {{PAD_W{1'b0}}, addr};
      rom_lim = scaled_limit(ROM_MIN, ROM_MAX, int'(rom_field));
      ram_lim = scaled_limit(RAM_MIN, RAM_MAX, int'(ram_field));
      hit_rom = (addr_l >= ROM_BASE) && (addr_l < ROM_BASE + rom_lim);
      hit_ram = (addr_l >= RAM_BASE) && (addr_l < RAM_BASE + ram_lim);
      hit_win = (addr_l >= WIN_BASE) && (addr_l < WIN_BASE + WIN_SIZE);
      region  = RGN_NONE;
      if (valid) begin
         if (hit_win)      region = RGN_WIN;
         else if (hit_rom) region = RGN_ROM;
         else if (hit_ram) region = RGN_RAM;
      end
   end

endmodule

// File: rtl/at_reg_window.sv
module at_reg_window #(
   parameter int          DATA_W    = 32,
   parameter int          WORDS     = 64,
   parameter int          CTRL_IDX  = 0,
   parameter logic [31:0] CTRL_MASK = 32'h0000_000B,
   parameter int          CFG_IDX   = 4,
   parameter int          SZ_W      = 3,
   parameter int          ROM_LSB   = 0,
   parameter int          RAM_LSB   = 8,
   localparam int         IDX_W     = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ctl_pdown,
   output logic              ctl_sreset,
   output logic              ctl_prot,
   output logic [SZ_W-1:0]   rom_field,
   output logic [SZ_W-1:0]   ram_field
);
   localparam logic [DATA_W-1:0] KEEP_CTRL = DATA_W'(CTRL_MASK);

   logic [DATA_W-1:0] word_q [WORDS];

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      if (g == CTRL_IDX) begin : g_ctrl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            word_q[g] <= '0;
            else if (wr_en && idx == IDX_W'(g))    word_q[g] <= wdata & KEEP_CTRL;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            word_q[g] <= '0;
            else if (wr_en && idx == IDX_W'(g))    word_q[g] <= wdata;
         end
      end
   end

   logic [DATA_W-1:0] ctrl_w;
   logic [DATA_W-1:0] cfg_w;

   always_comb begin
      rdata      = word_q[idx];
      ctrl_w     = word_q[CTRL_IDX];
      cfg_w      = word_q[CFG_IDX];
      ctl_pdown  = ctrl_w[0];
      ctl_sreset = ctrl_w[1];
      ctl_prot   = ctrl_w[3];
      rom_field  = cfg_w[ROM_LSB +: SZ_W];
      ram_field  = cfg_w[RAM_LSB +: SZ_W];
   end

endmodule

// File: rtl/at_trap_capture.sv
module at_trap_capture #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss,
   input  logic [ADDR_W-1:0] addr,
   output logic              trap_pulse,
   output logic [ADDR_W-1:0] trap_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_pulse <= 1'b0;
         trap_addr  <= '0;
      end else begin
         trap_pulse <= miss;
         if (miss) trap_addr <= addr;
      end
   end
endmodule

// File: rtl/addr_trap_decoder.sv
module addr_trap_decoder
   import addr_trap_pkg::*;
#(
   parameter int              ADDR_W   = 32,
   parameter int              DATA_W   = 32,
   parameter int              SZ_W     = 3,
   parameter longint unsigned ROM_BASE = 64'h0,
   parameter longint unsigned ROM_MIN  = 64'h1000,
   parameter longint unsigned ROM_MAX  = 64'h8_0000,
   parameter longint unsigned RAM_BASE = 64'h0200_0000,
   parameter longint unsigned RAM_MIN  = 64'h4_0000,
   parameter longint unsigned RAM_MAX  = 64'h40_0000,
   parameter longint unsigned WIN_BASE = 64'h01F8_0000,
   parameter longint unsigned WIN_SIZE = 64'h100,
   parameter int              CTRL_OFF = 'h00,
   parameter int              CFG_OFF  = 'h10,
   parameter int              ROM_LSB  = 0,
   parameter int              RAM_LSB  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              sel_rom,
   output logic              sel_ram,
   output logic              sel_regs,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              trap_pulse,
   output logic [ADDR_W-1:0] trap_addr,
   output logic              prot_en,
   output logic              pdown_en,
   output logic              sreset_en
);
   localparam int BYTES_W  = DATA_W / 8;
   localparam int BOFF_W   = $clog2(BYTES_W);
   localparam int WORDS    = int'(WIN_SIZE) / BYTES_W;
   localparam int IDX_W    = $clog2(WORDS);
   localparam int CTRL_IDX = CTRL_OFF / BYTES_W;
   localparam int CFG_IDX  = CFG_OFF / BYTES_W;

   // elaboration-time parameter checks
   if (ADDR_W < 8 || ADDR_W > 63) begin : g_bad_aw
      $fatal(1, "ADDR_W out of range");
   end
   if (DATA_W % 8 != 0 || !is_pow2(longint'(BYTES_W)) || DATA_W < 16) begin : g_bad_dw
      $fatal(1, "DATA_W must be a power-of-two byte count of at least 16 bits");
   end
   if (!is_pow2(WIN_SIZE) || WORDS > 1024 || WORDS < 2) begin : g_bad_win
      $fatal(1, "WIN_SIZE must be a power of two giving 2..1024 words");
   end
   if (!is_pow2(ROM_MIN) || !is_pow2(RAM_MIN) || ROM_MAX < ROM_MIN || RAM_MAX < RAM_MIN) begin : g_bad_sz
      $fatal(1, "region sizes inconsistent");
   end
   if (CTRL_IDX >= WORDS || CFG_IDX >= WORDS || CTRL_IDX == CFG_IDX) begin : g_bad_off
      $fatal(1, "control and configuration offsets must be distinct and inside the window");
   end
   if (ROM_LSB + SZ_W > DATA_W || RAM_LSB + SZ_W > DATA_W) begin : g_bad_fld
      $fatal(1, "size fields exceed the data width");
   end

   region_e          region;
   logic [SZ_W-1:0]  rom_field;
   logic [SZ_W-1:0]  ram_field;
   logic [DATA_W-1:0] win_rdata;
   logic             miss;
   logic             win_wr;

   at_region_decode #(
      .ADDR_W(ADDR_W), .SZ_W(SZ_W),
      .ROM_BASE(ROM_BASE), .ROM_MIN(ROM_MIN), .ROM_MAX(ROM_MAX),
      .RAM_BASE(RAM_BASE), .RAM_MIN(RAM_MIN), .RAM_MAX(RAM_MAX),
      .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
   ) dec_i (
      .valid     (req_valid),
      .addr      (req_addr),
      .rom_field (rom_field),
      .ram_field (ram_field),
      .region    (region)
   );

   always_comb begin
      sel_rom  = (region == RGN_ROM);
      sel_ram  = (region == RGN_RAM);
      sel_regs = (region == RGN_WIN);
      miss     = req_valid && (region == RGN_NONE);
      win_wr   = sel_regs && req_write;
   end

   at_reg_window #(
      .DATA_W(DATA_W), .WORDS(WORDS),
      .CTRL_IDX(CTRL_IDX), .CTRL_MASK(32'h0000_000B), .CFG_IDX(CFG_IDX),
      .SZ_W(SZ_W), .ROM_LSB(ROM_LSB), .RAM_LSB(RAM_LSB)
   ) win_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (win_wr),
      .idx        (req_addr[BOFF_W +: IDX_W]),
      .wdata      (req_wdata),
      .rdata      (win_rdata),
      .ctl_pdown  (pdown_en),
      .ctl_sreset (sreset_en),
      .ctl_prot   (prot_en),
      .rom_field  (rom_field),
      .ram_field  (ram_field)
   );

   at_trap_capture #(.ADDR_W(ADDR_W)) trap_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss       (miss),
      .addr       (req_addr),
      .trap_pulse (trap_pulse),
      .trap_addr  (trap_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !miss;
         rsp_rdata <= (sel_regs && !req_write) ? win_rdata : '0;
      end
   end

endmodule

// File: rtl/addr_trap_chk.sv
module addr_trap_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int IDX_LO = 2,
   parameter int IDX_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              sel_rom,
   input logic              sel_ram,
   input logic              sel_regs,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              trap_pulse,
   input logic [ADDR_W-1:0] trap_addr,
   input logic              prot_en,
   input logic              pdown_en,
   input logic              sreset_en
);
   logic any_sel;
   assign any_sel = sel_rom | sel_ram | sel_regs;

   assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_rom, sel_ram, sel_regs}));

   assert_sel_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      any_sel |-> req_valid);

   assert_window_no_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_regs |=> !trap_pulse);

   assert_trap_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !any_sel) |=> (trap_pulse && !rsp_valid && trap_addr == $past(req_addr)));

   assert_trap_only_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !any_sel) |=> !trap_pulse);

   assert_ctrl_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_regs && req_write && req_addr[IDX_LO +: IDX_W] == '0) |=>
         (prot_en == $past(req_wdata[3]) && pdown_en == $past(req_wdata[0])
          && sreset_en == $past(req_wdata[1])));

   assert_trap_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_pulse |-> $stable(trap_addr));

   assert_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_regs && !req_write) |=> (rsp_rdata == '0));

   assert_rsp_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      any_sel |=> rsp_valid);
endmodule

bind addr_trap_decoder addr_trap_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_LO(BOFF_W), .IDX_W(IDX_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_wdata(req_wdata), .sel_rom(sel_rom),
   .sel_ram(sel_ram), .sel_regs(sel_regs), .rsp_valid(rsp_valid),
   .rsp_rdata(rsp_rdata), .trap_pulse(trap_pulse), .trap_addr(trap_addr),
   .prot_en(prot_en), .pdown_en(pdown_en), .sreset_en(sreset_en)
);

// File: tb/addr_trap_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_trap_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        sel_rom, sel_ram, sel_regs, rsp_valid, trap_pulse;
   logic        prot_en, pdown_en, sreset_en;
   logic [31:0] rsp_rdata, trap_addr;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench model
   logic [31:0] mdl [64];
   int unsigned m_rom_f = 0;
   int unsigned m_ram_f = 0;
   logic [31:0] last_trap = '0;

   always #2.5 clk = ~clk;

   addr_trap_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .sel_rom(sel_rom),
      .sel_ram(sel_ram), .sel_regs(sel_regs), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .trap_pulse(trap_pulse), .trap_addr(trap_addr),
      .prot_en(prot_en), .pdown_en(pdown_en), .sreset_en(sreset_en)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic longint unsigned rom_lim();
      longint unsigned s = 64'h1000 << m_rom_f;
      return (s > 64'h8_0000) ? 64'h8_0000 : s;
   endfunction

   function automatic longint unsigned ram_lim();
      longint unsigned s = 64'h4_0000 << m_ram_f;
      return (s > 64'h40_0000) ? 64'h40_0000 : s;
   endfunction

   // 0 none, 1 rom, 2 ram, 3 window
   function automatic int exp_region(input logic [31:0] a);
      longint unsigned al = {32'h0, a};
      if (al >= 64'h01F8_0000 && al < 64'h01F8_0100) return 3;
      if (al < rom_lim()) return 1;
      if (al >= 64'h0200_0000 && al < 64'h0200_0000 + ram_lim()) return 2;
      return 0;
   endfunction

   function automatic string rtag(input int r);
      case (r)
         1: return "R2";
         2: return "R3";
         3: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d);
      int          r;
      logic [31:0] exp_rd;
      logic [2:0]  exp_sel;
      int          idx;
      @(negedge clk);
      chk(trap_pulse == 1'b0, "R5 pulse one cycle", {31'b0, trap_pulse}, 32'h0);
      req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
      #1;
      r = exp_region(a);
      exp_sel = (r == 1) ? 3'b100 : (r == 2) ? 3'b010 : (r == 3) ? 3'b001 : 3'b000;
      chk({sel_rom, sel_ram, sel_regs} == exp_sel, rtag(r), {29'b0, sel_rom, sel_ram, sel_regs}, {29'b0, exp_sel});
      idx = int'(a[7:2]);
      exp_rd = (r == 3 && !we) ? mdl[idx] : 32'h0;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      chk(trap_pulse == (r == 0), "R5 trap", {31'b0, trap_pulse}, {31'b0, (r == 0)});
      chk(rsp_valid == (r != 0), "R9 rsp_valid", {31'b0, rsp_valid}, {31'b0, (r != 0)});
      chk(rsp_rdata == exp_rd, (r == 3) ? "R4 readback" : "R9 zero data", rsp_rdata, exp_rd);
      if (r == 0) last_trap = a;
      chk(trap_addr == last_trap, (r == 0) ? "R5 trap_addr" : "R8 trap_addr hold", trap_addr, last_trap);
      if (we && r == 3) begin
         if (idx == 0) mdl[0] = d & 32'h0000_000B;
         else          mdl[idx] = d;
         if (idx == 4) begin
            m_rom_f = int'(d[2:0]);
            m_ram_f = int'(d[10:8]);
         end
      end
      chk({pdown_en, sreset_en, prot_en} == {mdl[0][0], mdl[0][1], mdl[0][3]}, "R7 control outs",
          {29'b0, pdown_en, sreset_en, prot_en}, {29'b0, mdl[0][0], mdl[0][1], mdl[0][3]});
   endtask

   function automatic logic [31:0] pick_addr();
      int unsigned k = $urandom % 7;
      logic [31:0] a;
      case (k)
         0: a = 32'(rom_lim()) - 32'd8 + ($urandom % 16);
         1: a = 32'h0200_0000 + 32'(ram_lim()) - 32'd8 + ($urandom % 16);
         2: a = 32'h01F8_0000 + ($urandom % 64) * 4;
         3: a = ($urandom % 2) ? 32'h01F8_0100 + ($urandom % 8) * 4 : 32'h01F7_FFFC;
         4: a = $urandom;
         5: a = 32'h0200_0000 - 32'd4 - ($urandom % 64) * 4;
         default: a = $urandom % 32'h0001_0000;
      endcase
      return {a[31:2], 2'b00};
   endfunction

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 64; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(rsp_valid == 0 && trap_pulse == 0, "R1 reset outputs", {30'b0, rsp_valid, trap_pulse}, 32'h0);
      chk(trap_addr == 0, "R1 reset trap_addr", trap_addr, 32'h0);
      chk({prot_en, pdown_en, sreset_en} == 3'b000, "R1 reset control", {29'b0, prot_en, pdown_en, sreset_en}, 32'h0);
      rst_n = 1'b1;
      // R1: reset sizes
      access(0, 32'h0000_0FFC, 0);
      access(0, 32'h0000_1000, 0);
      access(0, 32'h0203_FFFC, 0);
      access(1, 32'h0204_0000, 32'hDEAD_BEEF);
      access(0, 32'h01F8_0010, 0);
      // R4: unused word storage
      access(1, 32'h01F8_0040, 32'hA5A5_1234);
      access(0, 32'h01F8_0040, 0);
      access(0, 32'h01F8_0100, 0);
      access(0, 32'h01F7_FFFC, 0);
      access(1, 32'h01F8_00FC, 32'h0BAD_F00D);
      access(0, 32'h01F8_00FC, 0);
      // R7: control word keeps only bits 0,1,3
      access(1, 32'h01F8_0000, 32'hFFFF_FFFF);
      access(0, 32'h01F8_0000, 0);
      access(1, 32'h01F8_0000, 32'h0000_0008);
      // R6: grow both regions, spare bits read back
      access(1, 32'h01F8_0010, 32'hFFFF_F4F7);
      access(0, 32'h01F8_0010, 0);
      access(0, 32'h0007_FFFC, 0);
      access(0, 32'h0008_0000, 0);
      access(0, 32'h023F_FFFC, 0);
      access(0, 32'h0240_0000, 0);
      // R6: cap at field 7
      access(1, 32'h01F8_0010, 32'h0000_0707);
      access(0, 32'h0240_0000, 0);
      access(0, 32'h023F_FFFC, 0);
      // R8: trap_addr holds across hits
      access(0, 32'h8000_0000, 0);
      access(0, 32'h0000_0000, 0);
      access(0, 32'h01F8_0004, 0);
      // random mix
      for (int n = 0; n < 400; n++) begin
         if ($urandom % 12 == 0)
            access(1, 32'h01F8_0010, $urandom);
         else
            access($urandom % 2, pick_addr(), $urandom);
      end
      finished = 1'b1;
      finish_run();
   end
endmodule